// File: doc/BRIEF.md
# Command Ring Consumer

This block drains a circular queue of 32-byte commands held in memory. Software places commands in the ring, then moves the producer pointer forward by writing it. When that write arrives while the unit is enabled and the new pointer is valid and differs from the consumer's read position, the block starts working. For each entry it reads four 64-bit words from memory, lowest address first. If the opcode is one it hands off, it presents the whole 256-bit command to a downstream decoder and waits for that decoder to finish. It then moves the read position forward, wrapping at the end of the ring. It keeps going until the read position catches up with the producer pointer.

The producer pointer can be written as one 64-bit value or as two 32-bit halves. Only a full write or a write to the lower half starts processing. A pointer that is misaligned or beyond the end of the ring is rejected with an error flag. A memory read error halts the drain on the failing entry, so the next valid pointer write retries that entry.

Top module: `cmd_ring_consumer`

## Requirements
- R1: After reset `rd_ptr` is 0 and `busy`, `err_wptr`, `err_mem`, `mem_req` and `cmd_valid` are all low.
- R2: A write with `wp_wr_full` or `wp_wr_lo` while `enable` is high starts a drain when the new pointer is valid and its index (bits 63:5) differs from the read index. While `enable` is low such a write only stores the pointer.
- R3: A write with `wp_wr_hi` replaces bits 63:32 of the stored pointer and never starts a drain.
- R4: A triggering write whose bits 4:0 are not zero, or whose index is not below `q_entries`, sets `err_wptr` and fetches nothing. The next triggering write with a valid pointer clears it.
- R5: An entry at read index i is fetched as four requests at addresses `q_base + 32*i + 8*k`, for k = 0,1,2,3 in that order. Each request holds `mem_req` and `mem_addr` steady until `mem_rvalid`.
- R6: An entry whose opcode (word 0, bits 7:0) is 0x05, 0x08 or 0x09 is presented on `cmd_words`, with word k in bits 64k+63:64k. `cmd_valid` stays high until `cmd_done`, and the read index advances only after that.
- R7: An entry with any other opcode is skipped without raising `cmd_valid`, and the read index still advances.
- R8: The read index wraps from `q_entries`-1 to 0.
- R9: `rd_ptr` equals the read index shifted left by 5, and all other bits are zero.
- R10: A fetch answered with `mem_rerr` ends the drain. It sets `err_mem` and leaves `rd_ptr` on the failing entry. The next valid triggering write clears `err_mem` and fetches that entry again.
- R11: `busy` is high while a drain is in progress, and `rd_ptr` changes only while busy. Pointer writes made during a drain are compared again after each entry, so the drain ends at the latest valid pointer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| enable | input | 1 | Unit enable |
| wp_wr_full | input | 1 | 64-bit write strobe for the producer pointer |
| wp_wr_lo | input | 1 | Strobe for a write to the lower 32 bits of the producer pointer |
| wp_wr_hi | input | 1 | Strobe for a write to the upper 32 bits of the producer pointer |
| wp_wdata | input | 64 | Write data; for half writes, the matching half is used |
| q_base | input | ADDR_W | Byte address of ring entry 0 |
| q_entries | input | IDX_W+1 | Number of entries in the ring |
| rd_ptr | output | 64 | Read pointer register value |
| busy | output | 1 | Drain in progress |
| err_wptr | output | 1 | Last triggering pointer write was invalid |
| err_mem | output | 1 | Drain halted on a memory error |
| mem_req | output | 1 | Memory read request |
| mem_addr | output | ADDR_W | Memory read byte address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 64 | Read response data |
| mem_rerr | input | 1 | Read response error |
| cmd_valid | output | 1 | Command presented to the decoder |
| cmd_words | output | 256 | Four command words |
| cmd_done | input | 1 | Decoder finished the presented command |

## Verification
A corrupted read index appears at once on `rd_ptr` and on the next `mem_addr`. A bench that compares the final pointer and each handed-off command's embedded address catches it within one entry. A wrong beat counter shows up in the handed-off command as words whose addresses are not in ascending steps of 8. A skipped or doubled hand-off changes the decoder's count at the end of the drain. A stuck state machine leaves `busy` high, and the run stops on a timeout. An error flag set or cleared at the wrong time is visible on its own pin as soon as the drain ends.

// File: rtl/cmd_ring_consumer.sv
module cmd_ring_consumer #(
  parameter int ADDR_W = 48,
  parameter int IDX_W  = 15,
  parameter logic [7:0] OP_SYNC     = 8'h05,
  parameter logic [7:0] OP_MAP_DEV  = 8'h08,
  parameter logic [7:0] OP_MAP_COLL = 8'h09
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                wp_wr_full,
  input  logic                wp_wr_lo,
  input  logic                wp_wr_hi,
  input  logic [63:0]         wp_wdata,
  input  logic [ADDR_W-1:0]   q_base,
  input  logic [IDX_W:0]      q_entries,
  output logic [63:0]         rd_ptr,
  output logic                busy,
  output logic                err_wptr,
  output logic                err_mem,
  output logic                mem_req,
  output logic [ADDR_W-1:0]   mem_addr,
  input  logic                mem_rvalid,
  input  logic [63:0]         mem_rdata,
  input  logic                mem_rerr,
  output logic                cmd_valid,
  output logic [255:0]        cmd_words,
  input  logic                cmd_done
);

  localparam int SHIFT  = 5;
  localparam int BEATS  = 4;
  localparam int BEAT_W = $clog2(BEATS);
  localparam int HI_W   = 64 - SHIFT;

  typedef enum logic [1:0] {S_IDLE, S_FETCH, S_HAND, S_ADV} state_t;

  state_t                    state;
  logic [63:0]               wp_q, wp_next;
  logic [IDX_W-1:0]          rd_idx, nxt_idx;
  logic [BEAT_W-1:0]         beat;
  logic [BEATS-1:0][63:0]    words_q;
  logic                      trig, bad, wp_err_eff, go_on, handed;

  always_comb begin
    wp_next = wp_q;
    if (wp_wr_full)
      wp_next = wp_wdata;
    else begin
      if (wp_wr_lo) wp_next[31:0]  = wp_wdata[31:0];
      if (wp_wr_hi) wp_next[63:32] = wp_wdata[63:32];
    end
  end

  assign trig       = enable && (wp_wr_full || wp_wr_lo);
  assign bad        = (wp_next[SHIFT-1:0] != '0) || (wp_next[63:SHIFT] >= HI_W'(q_entries));
  assign wp_err_eff = trig ? bad : err_wptr;
  assign nxt_idx    = ((IDX_W+1)'(rd_idx) + 1'b1 == q_entries) ? '0 : rd_idx + 1'b1;
  assign go_on      = enable && !wp_err_eff && (wp_next[SHIFT +: IDX_W] != nxt_idx);

  function automatic logic is_handled(input logic [7:0] op);
    return (op == OP_SYNC) || (op == OP_MAP_DEV) || (op == OP_MAP_COLL);
  endfunction

  assign handed    = is_handled(words_q[0][7:0]);
  assign busy      = (state != S_IDLE);
  assign rd_ptr    = 64'({rd_idx, SHIFT'(0)});
  assign mem_req   = (state == S_FETCH);
  assign mem_addr  = q_base + ADDR_W'({rd_idx, SHIFT'(0)}) + ADDR_W'({beat, 3'b000});
  assign cmd_valid = (state == S_HAND);
  assign cmd_words = words_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      wp_q     <= '0;
      rd_idx   <= '0;
      beat     <= '0;
      words_q  <= '0;
      err_wptr <= 1'b0;
      err_mem  <= 1'b0;
    end else begin
      if (wp_wr_full || wp_wr_lo || wp_wr_hi) wp_q <= wp_next;
      if (trig) err_wptr <= bad;
      unique case (state)
        S_IDLE: begin
          if (trig && !bad) begin
            err_mem <= 1'b0;
            if (wp_next[SHIFT +: IDX_W] != rd_idx) begin
              state <= S_FETCH;
              beat  <= '0;
            end
          end
        end
        S_FETCH: begin
          if (mem_rvalid) begin
            if (mem_rerr) begin
              err_mem <= 1'b1;
              state   <= S_IDLE;
              beat    <= '0;
            end else begin
              words_q[beat] <= mem_rdata;
              beat          <= beat + 1'b1;
              if (beat == BEAT_W'(BEATS-1))
                state <= handed ? S_HAND : S_ADV;
            end
          end
        end
        S_HAND: begin
          if (cmd_done) state <= S_ADV;
        end
        S_ADV: begin
          rd_idx <= nxt_idx;
          beat   <= '0;
          state  <= go_on ? S_FETCH : S_IDLE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr))) else $error("req dropped"); // R5

  AST_CMD_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && !cmd_done) |=> cmd_valid) else $error("cmd_valid dropped"); // R6

  AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid |-> !mem_req) else $error("hand-off during fetch"); // R6

  AST_PTR_ONLY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> $past(busy)) else $error("rd_ptr moved while idle"); // R11

  AST_MEMERR_HOLDS_PTR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(err_mem) |-> ($stable(rd_ptr) && !busy)) else $error("err_mem moved pointer"); // R10

  AST_BADPTR_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (err_wptr && !busy) |-> !mem_req) else $error("fetch after bad pointer"); // R4

endmodule

// File: tb/tb_cmd_ring_consumer.sv
module tb_cmd_ring_consumer;
  localparam int ADDR_W = 48;
  localparam int IDX_W  = 15;
  localparam int N_ENT  = 8;
  localparam logic [ADDR_W-1:0] BASE = 48'h0000_1234_0000;
  localparam int NV = 6;
  localparam int TGT [NV] = '{3, 5, 7, 2, 2, 0};

  logic clk = 0, rst_n = 0, enable = 0;
  logic wp_wr_full = 0, wp_wr_lo = 0, wp_wr_hi = 0;
  logic [63:0] wp_wdata = '0;
  logic [ADDR_W-1:0] q_base = BASE;
  logic [IDX_W:0] q_entries = (IDX_W+1)'(N_ENT);
  logic [63:0] rd_ptr;
  logic busy, err_wptr, err_mem, mem_req, cmd_valid;
  logic [ADDR_W-1:0] mem_addr;
  logic mem_rvalid = 0, mem_rerr = 0, cmd_done = 0;
  logic [63:0] mem_rdata = '0;
  logic [255:0] cmd_words;
  logic [ADDR_W-1:0] err_addr = '1;

  int n_chk = 0, n_err = 0, hands = 0, req_cycles = 0, cyc = 0;

  cmd_ring_consumer #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .wp_wr_full(wp_wr_full), .wp_wr_lo(wp_wr_lo),
    .wp_wr_hi(wp_wr_hi), .wp_wdata(wp_wdata), .q_base(q_base), .q_entries(q_entries),
    .rd_ptr(rd_ptr), .busy(busy), .err_wptr(err_wptr), .err_mem(err_mem), .mem_req(mem_req),
    .mem_addr(mem_addr), .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .mem_rerr(mem_rerr),
    .cmd_valid(cmd_valid), .cmd_words(cmd_words), .cmd_done(cmd_done));

  always #2.5 clk = ~clk;

  function automatic logic [7:0] op_of(int i);
    case (i % 4)
      0: return 8'h05;
      1: return 8'h08;
      2: return 8'h03;
      default: return 8'h09;
    endcase
  endfunction

  function automatic logic [63:0] mem_word(logic [ADDR_W-1:0] a);
    int idx = int'((a - BASE) >> 5);
    return {a, 8'hA5, (a[4:3] == 2'b00) ? op_of(idx) : 8'hEE};
  endfunction

  function automatic int hands_between(int a, int b);
    int n = 0;
    int i = a;
    while (i != b) begin
      if (op_of(i) != 8'h03) n++;
      i = (i + 1) % N_ENT;
    end
    return n;
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  always @(posedge clk) begin
    if (mem_req && !mem_rvalid) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= mem_word(mem_addr);
      mem_rerr   <= (mem_addr == err_addr);
    end else begin
      mem_rvalid <= 1'b0;
      mem_rerr   <= 1'b0;
    end
    if (mem_req) req_cycles++;
    cmd_done <= cmd_valid && !cmd_done;
  end

  always @(negedge clk) begin
    if (cmd_valid && cmd_done) begin
      logic [47:0] a0;
      a0 = cmd_words[63:16];
      hands++;
      check("R5 beat1 addr", 64'(cmd_words[127:80]),  64'(a0 + 48'd8));
      check("R5 beat3 addr", 64'(cmd_words[255:208]), 64'(a0 + 48'd24));
      check("R6 handed opcode", 64'(op_of(int'((a0 - BASE) >> 5))), 64'(cmd_words[7:0]));
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc == 100000) begin
      n_err++; n_chk++;
      $display("FAIL watchdog: actual=hung expected=idle");
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  task automatic wr(input int kind, input logic [63:0] v);
    @(negedge clk);
    wp_wdata = v;
    wp_wr_full = (kind == 0); wp_wr_lo = (kind == 1); wp_wr_hi = (kind == 2);
    @(negedge clk);
    wp_wr_full = 0; wp_wr_lo = 0; wp_wr_hi = 0;
  endtask

  task automatic wait_idle();
    repeat (2) @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  initial begin
    int cur;
    int h0;
    int rq0;
    bit saw_busy;
    repeat (3) @(negedge clk);
    check("R1 rd_ptr", rd_ptr, 0);
    check("R1 busy", 64'(busy), 0);
    check("R1 err_wptr", 64'(err_wptr), 0);
    check("R1 err_mem", 64'(err_mem), 0);
    check("R1 mem_req", 64'(mem_req), 0);
    check("R1 cmd_valid", 64'(cmd_valid), 0);
    rst_n = 1;
    enable = 1;
    cur = 0;
    for (int v = 0; v < NV; v++) begin
      h0 = hands;
      wr(v % 2, 64'(TGT[v]) << 5);
      wait_idle();
      check("R2/R8/R9 rd_ptr", rd_ptr, 64'(TGT[v]) << 5);
      check("R6/R7 hand-offs", 64'(hands - h0), 64'(hands_between(cur, TGT[v])));
      check("R2 no error", 64'({err_wptr, err_mem}), 0);
      cur = TGT[v];
    end
    // R10: error on entry 1 beat 2
    err_addr = BASE + 48'd32 + 48'd16;
    h0 = hands;
    wr(1, 64'd4 << 5);
    wait_idle();
    check("R10 rd_ptr stays", rd_ptr, 64'd1 << 5);
    check("R10 err_mem", 64'(err_mem), 1);
    check("R10 hand-offs before error", 64'(hands - h0), 1);
    err_addr = '1;
    wr(1, 64'd4 << 5);
    wait_idle();
    check("R10 retry rd_ptr", rd_ptr, 64'd4 << 5);
    check("R10 err_mem cleared", 64'(err_mem), 0);
    // R4: out of range and equal-to-size and misaligned
    rq0 = req_cycles;
    wr(0, 64'd9 << 5);
    wait_idle();
    check("R4 err_wptr beyond", 64'(err_wptr), 1);
    check("R4 rd_ptr unchanged", rd_ptr, 64'd4 << 5);
    check("R4 no fetch", 64'(req_cycles - rq0), 0);
    wr(1, (64'd6 << 5) | 64'd3);
    wait_idle();
    check("R4 err_wptr misaligned", 64'(err_wptr), 1);
    wr(1, 64'(N_ENT) << 5);
    wait_idle();
    check("R4 err_wptr equal size", 64'(err_wptr), 1);
    check("R4 no fetch total", 64'(req_cycles - rq0), 0);
    wr(1, 64'd4 << 5);
    wait_idle();
    check("R4 err_wptr cleared", 64'(err_wptr), 0);
    // R2: disabled write only stores
    enable = 0;
    wr(1, 64'd6 << 5);
    wait_idle();
    check("R2 disabled no drain", rd_ptr, 64'd4 << 5);
    // R3: high-half write never triggers
    enable = 1;
    wr(2, 64'h0);
    wait_idle();
    check("R3 hi write no drain", rd_ptr, 64'd4 << 5);
    wr(1, 64'd6 << 5);
    wait_idle();
    check("R2 lo write drains", rd_ptr, 64'd6 << 5);
    // R11: pointer moved during a drain
    wr(1, 64'd7 << 5);
    saw_busy = busy;
    wr(1, 64'd1 << 5);
    wait_idle();
    check("R11 busy seen", 64'(saw_busy), 1);
    check("R11 latest pointer reached", rd_ptr, 64'd1 << 5);
    check("R8 wrapped idle", 64'(busy), 0);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule